// File: doc/BRIEF.md
# VLIW Issue Group Former

This block accepts a stream of fixed 128-bit instruction bundles, each carrying three primitive operations of 40 bits, and regroups those operations into issue groups of variable length. A group ends at the first operation whose stop bit is set. It may draw operations from several consecutive bundles, so one group can span bundle boundaries. Operations that follow a stop bit inside a bundle are kept and open the next group.

Each finished group appears on a registered output as up to six operation slots, filled from slot 0 upward in program order, with a contiguous slot-valid mask. Both sides use a valid/ready handshake. If six operations arrive without a stop bit, the block issues those six as a group and raises a sticky malformed-group flag. The input is held off whenever the operations already buffered plus one more bundle would not fit in the eight-entry holding store.

Top module: `vgf_group_former`

## Requirements
- R1: After a synchronous reset, out_valid and malformed are 0 and in_ready is 1.
- R2: A bundle holds op0 in bits [39:0], op1 in [79:40] and op2 in [119:80]. Bit 39 of each 40-bit op is its stop bit. Bits [127:120] have no effect on any output.
- R3: Operations leave in the order they arrived, slot 0 first. None is dropped or duplicated, operations after a stop bit in a bundle start the next group, and a group may take operations from more than one bundle.
- R4: A group closes at the first buffered operation with its stop bit set. No valid slot other than the highest valid slot carries a set stop bit.
- R5: While out_valid is 1, out_mask is nonzero and contiguous from bit 0, and its set bits match the number of operations in the group.
- R6: When six operations are buffered with no stop bit among them, they are issued as one group and malformed goes to 1. It stays 1 until reset.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_mask and out_ops hold their values.
- R8: in_ready is 0 exactly when the number of buffered operations plus 3 exceeds 8.
- R9: When a bundle is accepted at a rising edge and the output register is free, a group that it completes is presented after the following rising edge.
- R10: A reset asserted mid-stream discards all buffered operations and the pending output group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle present on in_bundle |
| in_ready | output | 1 | Holding store can take a whole bundle |
| in_bundle | input | 128 | Three operations plus reserved bits |
| out_valid | output | 1 | Group present on out_ops |
| out_ready | input | 1 | Consumer takes the group |
| out_mask | output | 6 | Slot-valid mask, contiguous from slot 0 |
| out_ops | output | 240 | Six 40-bit slots; slot s at bits [s*40+39:s*40] |
| malformed | output | 1 | Sticky: a group was forced out with no stop bit |

## Verification
The bench places stop bits at every position within a bundle, including several in one bundle and runs across bundles with none. A design that mishandles leftovers would drop or repeat the operations after a stop bit, and a design that scans past the first stop would issue merged groups. Long runs with no stop bit drive the forced six-operation path and the sticky flag. Random backpressure on out_ready fills the holding store to its limit, which exposes an off-by-one in the in_ready threshold as an overflow or a needless stall, and exposes an output register that changes while it is stalled. Reserved bits are randomised throughout, and a reset in the middle of the stream checks that no stale operation remains afterwards.

// File: rtl/vgf_pkg.sv
package vgf_pkg;
  localparam int OP_W      = 40;
  localparam int BUNDLE_W  = 128;
  localparam int OPS       = 3;
  localparam int GROUP_MAX = 6;
  localparam int HOLD      = 8;

  typedef logic [OP_W-1:0] op_t;
endpackage

// File: rtl/vgf_unpack.sv
module vgf_unpack
  import vgf_pkg::*;
#(
  parameter int BW  = BUNDLE_W,
  parameter int NOP = OPS
) (
  input  logic [BW-1:0] bundle,
  output op_t           ops [NOP]
);
  // Reserved bits above NOP*OP_W are left unconnected on purpose.
  for (genvar i = 0; i < NOP; i++) begin : g_slice
    assign ops[i] = bundle[i*OP_W +: OP_W];
  end

  logic unused_rsvd;
  assign unused_rsvd = ^bundle[BW-1:NOP*OP_W];
endmodule

// File: rtl/vgf_hold_queue.sv
module vgf_hold_queue
  import vgf_pkg::*;
#(
  parameter int DEPTH = HOLD,
  parameter int NOP   = OPS,
  parameter int NHEAD = GROUP_MAX,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  op_t           push_ops [NOP],
  input  logic [CW-1:0] pop_n,
  output logic [CW-1:0] count,
  output op_t           head [NHEAD]
);
  op_t           mem [DEPTH];
  op_t           nxt [DEPTH];
  logic [CW-1:0] nxt_count;

  always_comb begin
    int base;
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = '0;
      if (i + int'(pop_n) < DEPTH) nxt[i] = mem[i + int'(pop_n)];
    end
    base = int'(count) - int'(pop_n);
    if (push) begin
      for (int j = 0; j < NOP; j++)
        for (int i = 0; i < DEPTH; i++)
          if (i == base + j) nxt[i] = push_ops[j];
    end
    nxt_count = count - pop_n + (push ? CW'(NOP) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count <= nxt_count;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  for (genvar h = 0; h < NHEAD; h++) begin : g_head
    assign head[h] = mem[h];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(count) - int'(pop_n) + NOP <= DEPTH)); // R8
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (rst)
    pop_n <= count); // R3
endmodule

// File: rtl/vgf_group_pick.sv
module vgf_group_pick
  import vgf_pkg::*;
#(
  parameter int NHEAD = GROUP_MAX,
  parameter int DEPTH = HOLD,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  op_t           head [NHEAD],
  input  logic [CW-1:0] count,
  output logic [CW-1:0] take,
  output logic          forced
);
  always_comb begin
    logic found;
    found  = 1'b0;
    take   = '0;
    forced = 1'b0;
    for (int k = 0; k < NHEAD; k++) begin
      if (!found && k < int'(count) && head[k][OP_W-1]) begin
        found = 1'b1;
        take  = CW'(k + 1);
      end
    end
    if (!found && int'(count) >= NHEAD) begin
      take   = CW'(NHEAD);
      forced = 1'b1;
    end
  end
endmodule

// File: rtl/vgf_group_former.sv
module vgf_group_former
  import vgf_pkg::*;
#(
  parameter int BW    = BUNDLE_W,
  parameter int NOP   = OPS,
  parameter int GMAX  = GROUP_MAX,
  parameter int DEPTH = HOLD,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BW-1:0]      in_bundle,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [GMAX-1:0]    out_mask,
  output logic [GMAX*OP_W-1:0] out_ops,
  output logic               malformed
);
  op_t           new_ops [NOP];
  op_t           head    [GMAX];
  logic [CW-1:0] count;
  logic [CW-1:0] take;
  logic [CW-1:0] pop_n;
  logic          forced;
  logic          load;
  logic          push;

  vgf_unpack #(.BW(BW), .NOP(NOP)) u_unpack (
    .bundle (in_bundle),
    .ops    (new_ops)
  );

  vgf_hold_queue #(.DEPTH(DEPTH), .NOP(NOP), .NHEAD(GMAX)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_ops (new_ops),
    .pop_n    (pop_n),
    .count    (count),
    .head     (head)
  );

  vgf_group_pick #(.NHEAD(GMAX), .DEPTH(DEPTH)) u_pick (
    .head   (head),
    .count  (count),
    .take   (take),
    .forced (forced)
  );

  // Threshold uses the registered count only: no path from out_ready.
  assign in_ready = (int'(count) + NOP <= DEPTH);
  assign push     = in_valid && in_ready;
  assign load     = (!out_valid || out_ready) && (take != '0);
  assign pop_n    = load ? take : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_ops   <= '0;
      malformed <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      for (int s = 0; s < GMAX; s++) begin
        out_mask[s]              <= (s < int'(take));
        out_ops[s*OP_W +: OP_W]  <= (s < int'(take)) ? head[s] : '0;
      end
      if (forced) malformed <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask != '0) && ((out_mask & (out_mask + 1'b1)) == '0)); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_mask) && $stable(out_ops)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    malformed |=> malformed); // R6

  for (genvar s = 0; s < GMAX - 1; s++) begin : g_stop_chk
    AST_STOP_LAST: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_mask[s+1]) |-> !out_ops[s*OP_W + OP_W - 1]); // R4
  end
endmodule

// File: tb/vgf_group_former_test.sv
`timescale 1ns/1ps
module vgf_group_former_test;
  localparam int OPW = 40;
  localparam int NG  = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [127:0]   in_bundle = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [NG-1:0]  out_mask;
  logic [NG*OPW-1:0] out_ops;
  logic           malformed;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  logic [OPW-1:0] mq [$];
  logic           mv = 1'b0;
  logic [NG-1:0]  mmask = '0;
  logic [OPW-1:0] mops [NG];
  logic           merr = 1'b0;

  always #2.5 clk = ~clk;

  vgf_group_former uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_ops(out_ops), .malformed(malformed)
  );

  task automatic check(input bit ok, input string tag, input logic [OPW-1:0] act,
                       input logic [OPW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step(logic r, logic iv, logic [127:0] b, logic ordy);
    int  take;
    bit  forced;
    bit  found;
    bit  mrdy;
    if (r) begin
      mq.delete(); mv = 1'b0; mmask = '0; merr = 1'b0;   // R10
      return;
    end
    mrdy  = (mq.size() + 3 <= 8);
    take  = 0; forced = 0; found = 0;
    for (int k = 0; k < NG && k < mq.size(); k++)
      if (!found && mq[k][OPW-1]) begin found = 1; take = k + 1; end
    if (!found && mq.size() >= NG) begin take = NG; forced = 1; end
    if ((!mv || ordy) && take > 0) begin
      mv = 1'b1; mmask = '0;
      for (int k = 0; k < take; k++) begin
        mmask[k] = 1'b1;
        mops[k]  = mq.pop_front();
      end
      if (forced) merr = 1'b1;
    end else if (ordy) begin
      mv = 1'b0;
    end
    if (iv && mrdy)                                   // R2 layout
      for (int j = 0; j < 3; j++) mq.push_back(b[j*OPW +: OPW]);
  endfunction

  task automatic compare();
    check(in_ready === (mq.size() + 3 <= 8), "R8 in_ready", in_ready, mq.size() + 3 <= 8);
    check(out_valid === mv, "R9 out_valid", out_valid, mv);
    check(malformed === merr, "R6 malformed", malformed, merr);
    if (mv && out_valid) begin
      check(out_mask === mmask, "R5 out_mask", out_mask, mmask);
      for (int s = 0; s < NG; s++)
        if (mmask[s])
          check(out_ops[s*OPW +: OPW] === mops[s], "R3 slot op", out_ops[s*OPW +: OPW], mops[s]);
    end
  endtask

  task automatic step(input logic r, input logic iv, input logic [127:0] b, input logic ordy);
    @(negedge clk);
    compare();
    rst = r; in_valid = iv; in_bundle = b; out_ready = ordy;
    @(posedge clk);
    model_step(r, iv, b, ordy);
  endtask

  function automatic logic [127:0] mk(int stop_pct);
    logic [127:0] b;
    b = {$urandom, $urandom, $urandom, $urandom};     // R2 reserved bits random
    for (int j = 0; j < 3; j++) b[j*OPW + OPW - 1] = ($urandom % 100) < stop_pct;
    return b;
  endfunction

  function automatic logic [127:0] pat(logic [2:0] stops);
    logic [127:0] b;
    b = {$urandom, $urandom, $urandom, $urandom};
    for (int j = 0; j < 3; j++) b[j*OPW + OPW - 1] = stops[j];
    return b;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0, '0, 1'b0);
    step(1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b1);
    @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    check(malformed === 1'b0, "R1 malformed", malformed, 0);

    // R9 latency: single bundle with stop on op0, then idle
    step(1'b0, 1'b1, pat(3'b001), 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);

    // R3/R4 directed stop placements, including groups spanning bundles
    for (int p = 0; p < 8; p++) begin
      step(1'b0, 1'b1, pat(p[2:0]), 1'b1);
      step(1'b0, 1'b1, pat(3'b100), 1'b1);
    end
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, '0, 1'b1);

    // R3/R4 random, output always ready
    for (int i = 0; i < 600; i++) step(1'b0, ($urandom % 4) != 0, mk(40), 1'b1);
    // R7/R8 random backpressure
    for (int i = 0; i < 1200; i++) step(1'b0, ($urandom % 5) != 0, mk(30), ($urandom % 10) < 3);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, '0, 1'b1);

    // R6 long run with no stop bits
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, mk(0), ($urandom % 2) == 0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, '0, 1'b1);
    @(negedge clk);
    check(malformed === 1'b1, "R6 sticky set", malformed, 1);

    // R10 mid-stream reset with buffered operations and a stalled group
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, mk(20), 1'b0);
    step(1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b1);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid", out_valid, 0);
    check(malformed === 1'b0, "R10 malformed", malformed, 0);
    check(in_ready === 1'b1, "R10 in_ready", in_ready, 1);
    for (int i = 0; i < 400; i++) step(1'b0, ($urandom % 3) != 0, mk(35), ($urandom % 4) != 0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, '0, 1'b1);
    @(negedge clk);
    compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule